// File: doc/BRIEF.md
# FIFO Reset and Retransmit Controller

This block owns the write pointer (Port A clock domain) and the read pointer (Port B clock domain) of a dual-clock FIFO. It applies three active-low controls to them: a master reset, a partial reset and a retransmit strobe. During master reset it captures the configuration inputs on every Port A edge. These are the offset programming method, a choice among three default flag offsets, and the Port B bus width and byte order. The captured settings stay fixed until the next master reset.

Each clock domain counts its own rising edges while master reset is held low. A domain reports reset complete only when at least four of its edges fell inside the reset. A shorter reset is flagged as invalid, and the pointers of that domain stay frozen. Partial reset clears both pointers and the Port B output register, as master reset does. It leaves the configuration and the completion status alone. Retransmit moves the read pointer back to the first location, which is where the write pointer stood at the last reset. The write pointer is not touched.

All control inputs are assumed synchronous to the clock domain that samples them. The memory array, the flag arithmetic and serial offset loading lie outside this block.

Top module: `fifo_rr_ctrl`

## Requirements
- R1: While master reset is sampled low, the next Port A edge sets wr_ptr to 0 and the next Port B edge sets rd_ptr to 0 and raises obuf_clr.
- R2: Partial reset low clears wr_ptr and rd_ptr and raises obuf_clr in the same way. The configuration outputs and rst_done_a/rst_done_b keep their values.
- R3: Configuration inputs are captured on each Port A edge that samples master reset low. Once master reset is released, the configuration outputs hold the last captured values, whatever the inputs do.
- R4: cfg_offset decodes off_sel as 0→8, 1→16, 2→64 and 3→64. cfg_serial is 1 when prog_par was low at capture.
- R5: cfg_width is 0 (36-bit) when bm_en is low. With bm_en high it is 2 (9-bit) when size_byte is high and 1 (18-bit) when size_byte is low.
- R6: In each domain, rst_done goes high on the first edge that samples master reset high after at least 4 consecutive edges sampled it low. It goes low again on the next low sample.
- R7: If master reset is released after fewer than 4 edges of a domain, that domain's rst_bad goes high and its rst_done stays low. rst_bad clears on the next master reset.
- R8: On a Port A edge with wr_inc high, rst_done_a high and no reset, wr_ptr advances by one and wraps from DEPTH-1 to 0. Otherwise wr_inc is ignored.
- R9: On a Port B edge with rd_inc high, rst_done_b high and no reset, rd_ptr advances by one and wraps from DEPTH-1 to 0.
- R10: A Port B edge that samples rtx_n low after high arms a reload. On the following Port B edge rd_ptr becomes 0 and rd_reload is high for one cycle. The reload takes precedence over rd_inc, and wr_ptr is unaffected.
- R11: A retransmit strobe is ignored while rst_done_b is low or a reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A (write side) clock |
| clk_b | input | 1 | Port B (read side) clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| rtx_n | input | 1 | Retransmit strobe, active low |
| prog_par | input | 1 | Offset programming method: low serial, high parallel/default |
| off_sel | input | 2 | Default flag offset select |
| bm_en | input | 1 | Bus matching enable for Port B |
| size_byte | input | 1 | Port B 9-bit (high) or 18-bit (low) when bm_en is high |
| big_endian | input | 1 | Port B byte order |
| wr_inc | input | 1 | Advance write pointer |
| rd_inc | input | 1 | Advance read pointer |
| wr_ptr | output | AW | Write pointer |
| rd_ptr | output | AW | Read pointer |
| rd_reload | output | 1 | One-cycle pulse when retransmit reloads rd_ptr |
| obuf_clr | output | 1 | Clear for the Port B output register |
| rst_done_a | output | 1 | Port A domain saw a valid master reset |
| rst_done_b | output | 1 | Port B domain saw a valid master reset |
| rst_bad_a | output | 1 | Port A domain saw a too-short master reset |
| rst_bad_b | output | 1 | Port B domain saw a too-short master reset |
| cfg_serial | output | 1 | Latched serial programming select |
| cfg_offset | output | 7 | Latched default flag offset |
| cfg_width | output | 2 | Latched Port B width code |
| cfg_big_end | output | 1 | Latched Port B byte order |

## Verification
The bench releases master reset after only two Port A edges. It expects both invalid flags to rise, and it expects increments and retransmit strobes to be ignored afterwards. A design that counted edges wrongly, or that did not gate the pointers, would advance them or report completion. Partial reset is applied while the configuration inputs are driven to different values. A design that relatched them, or that cleared the completion status, would show changed outputs. Retransmit strobes arrive during random increments with rd_inc held high. A design that let the increment win, fired a cycle early, or disturbed wr_ptr would diverge from the bench's pointer model. A full wrap of wr_ptr exposes an off-by-one at DEPTH-1.

// File: rtl/fifo_rr_pkg.sv
package fifo_rr_pkg;

  typedef enum logic [1:0] {
    BW_36 = 2'd0,
    BW_18 = 2'd1,
    BW_9  = 2'd2
  } bus_w_e;

  typedef struct packed {
    logic       serial;
    logic [6:0] offset;
    bus_w_e     width;
    logic       big_end;
  } cfg_t;

  // default almost-full/empty offset chosen at master reset
  function automatic logic [6:0] offset_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd8;
      2'd1:    return 7'd16;
      default: return 7'd64;
    endcase
  endfunction

  function automatic bus_w_e width_of(input logic bm, input logic byte_sz);
    if (!bm)         return BW_36;
    else if (byte_sz) return BW_9;
    else             return BW_18;
  endfunction

  // pointer step with wrap at depth-1
  function automatic logic [31:0] ptr_step(input logic [31:0] p, input logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/rst_span_tracker.sv
module rst_span_tracker #(
  parameter int N_EDGES = 4
) (
  input  logic clk,
  input  logic mrst_n,
  output logic done,
  output logic bad
);
  localparam int CW = $clog2(N_EDGES + 1);

  logic [CW-1:0] cnt;
  logic          prev_low;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      if (prev_low) begin
        if (cnt < CW'(N_EDGES)) cnt <= cnt + CW'(1);
      end else begin
        cnt <= CW'(1);
      end
      prev_low <= 1'b1;
      done     <= 1'b0;
      bad      <= 1'b0;
    end else begin
      prev_low <= 1'b0;
      if (prev_low) begin
        done <= (cnt >= CW'(N_EDGES));
        bad  <= (cnt <  CW'(N_EDGES));
      end
    end
  end
endmodule

// File: rtl/cfg_capture.sv
module cfg_capture
  import fifo_rr_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  logic       prog_par,
  input  logic [1:0] off_sel,
  input  logic       bm_en,
  input  logic       size_byte,
  input  logic       big_endian,
  output cfg_t       cfg
);
  cfg_t next_cfg;

  always_comb begin
    next_cfg.serial  = ~prog_par;
    next_cfg.offset  = offset_of(off_sel);
    next_cfg.width   = width_of(bm_en, size_byte);
    next_cfg.big_end = big_endian;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) cfg <= next_cfg;
  end
endmodule

// File: rtl/fifo_rr_ctrl.sv
module fifo_rr_ctrl
  import fifo_rr_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int N_EDGES = 4,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          rtx_n,
  input  logic          prog_par,
  input  logic [1:0]    off_sel,
  input  logic          bm_en,
  input  logic          size_byte,
  input  logic          big_endian,
  input  logic          wr_inc,
  input  logic          rd_inc,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          rd_reload,
  output logic          obuf_clr,
  output logic          rst_done_a,
  output logic          rst_done_b,
  output logic          rst_bad_a,
  output logic          rst_bad_b,
  output logic          cfg_serial,
  output logic [6:0]    cfg_offset,
  output logic [1:0]    cfg_width,
  output logic          cfg_big_end
);
  localparam logic [AW-1:0] RTX_BASE = '0;

  cfg_t cfg;

  // named events for the checker
  logic ptr_clr;
  logic rtx_fall;
  logic rtx_hit;
  logic rtx_prev_n;
  logic wr_step_en;
  logic rd_step_en;

  rst_span_tracker #(.N_EDGES(N_EDGES)) u_trk_a (
    .clk(clk_a), .mrst_n(mrst_n), .done(rst_done_a), .bad(rst_bad_a)
  );

  rst_span_tracker #(.N_EDGES(N_EDGES)) u_trk_b (
    .clk(clk_b), .mrst_n(mrst_n), .done(rst_done_b), .bad(rst_bad_b)
  );

  cfg_capture u_cfg (
    .clk(clk_a), .mrst_n(mrst_n), .prog_par(prog_par), .off_sel(off_sel),
    .bm_en(bm_en), .size_byte(size_byte), .big_endian(big_endian), .cfg(cfg)
  );

  assign cfg_serial  = cfg.serial;
  assign cfg_offset  = cfg.offset;
  assign cfg_width   = cfg.width;
  assign cfg_big_end = cfg.big_end;

  assign ptr_clr    = !mrst_n || !prst_n;
  assign wr_step_en = wr_inc && rst_done_a;
  assign rd_step_en = rd_inc && rst_done_b;
  assign rtx_fall   = !rtx_n && rtx_prev_n && rst_done_b;

  // write side
  always_ff @(posedge clk_a) begin
    if (ptr_clr)         wr_ptr <= '0;
    else if (wr_step_en) wr_ptr <= AW'(ptr_step(32'(wr_ptr), 32'(DEPTH)));
  end

  // read side with retransmit
  always_ff @(posedge clk_b) begin
    if (ptr_clr) begin
      rd_ptr     <= '0;
      rtx_prev_n <= 1'b1;
      rtx_hit    <= 1'b0;
      rd_reload  <= 1'b0;
      obuf_clr   <= 1'b1;
    end else begin
      obuf_clr   <= 1'b0;
      rtx_prev_n <= rtx_n;
      rtx_hit    <= rtx_fall;
      rd_reload  <= rtx_hit;
      if (rtx_hit)         rd_ptr <= RTX_BASE;
      else if (rd_step_en) rd_ptr <= AW'(ptr_step(32'(rd_ptr), 32'(DEPTH)));
    end
  end
endmodule

// File: rtl/fifo_rr_checker.sv
module fifo_rr_checker #(
  parameter int N_EDGES = 4,
  parameter int AW      = 12
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          mrst_n,
  input logic          prst_n,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic          rd_reload,
  input logic          obuf_clr,
  input logic          rst_done_a,
  input logic          rst_done_b,
  input logic          rst_bad_a,
  input logic          rst_bad_b,
  input logic          cfg_serial,
  input logic [6:0]    cfg_offset,
  input logic [1:0]    cfg_width,
  input logic          cfg_big_end,
  input logic          rtx_hit
);
  logic [7:0] run_a, run_b;
  logic       low_a, low_b;
  logic       clr_seen_a, clr_seen_b;
  logic [10:0] cfg_pack;

  assign cfg_pack = {cfg_serial, cfg_offset, cfg_width, cfg_big_end};

  always @(posedge clk_a) begin
    if (!mrst_n) begin
      if (low_a) begin
        if (run_a < 8'd255) run_a <= run_a + 8'd1;
      end else run_a <= 8'd1;
      low_a <= 1'b1;
    end else low_a <= 1'b0;
  end

  always @(posedge clk_b) begin
    if (!mrst_n) begin
      if (low_b) begin
        if (run_b < 8'd255) run_b <= run_b + 8'd1;
      end else run_b <= 8'd1;
      low_b <= 1'b1;
    end else low_b <= 1'b0;
  end

  always @(posedge clk_a) begin
    if (clr_seen_a) begin
      AST_WPTR_CLEARED: assert (wr_ptr == '0) else $error("wr_ptr not cleared"); // R1
    end
    clr_seen_a <= !mrst_n || !prst_n;
  end

  always @(posedge clk_b) begin
    if (clr_seen_b) begin
      AST_RPTR_CLEARED: assert (rd_ptr == '0 && obuf_clr) else $error("rd side not cleared"); // R2
    end
    clr_seen_b <= !mrst_n || !prst_n;
  end

  AST_DONE_A_SPAN: assert property (@(posedge clk_a) disable iff (!mrst_n) $rose(rst_done_a) |-> 32'(run_a) >= N_EDGES); // R6
  AST_DONE_B_SPAN: assert property (@(posedge clk_b) disable iff (!mrst_n) $rose(rst_done_b) |-> 32'(run_b) >= N_EDGES); // R6
  AST_BAD_A_SHORT: assert property (@(posedge clk_a) disable iff (!mrst_n) $rose(rst_bad_a) |-> 32'(run_a) < N_EDGES); // R7
  AST_DONE_BAD_EXCL: assert property (@(posedge clk_b) disable iff (!mrst_n) !(rst_done_b && rst_bad_b)); // R7
  AST_CFG_HELD: assert property (@(posedge clk_a) disable iff (!mrst_n) $past(mrst_n) |-> $stable(cfg_pack)); // R3
  AST_RTX_RELOAD: assert property (@(posedge clk_b) disable iff (!mrst_n || !prst_n) rtx_hit |=> (rd_reload && rd_ptr == '0)); // R10
endmodule

bind fifo_rr_ctrl fifo_rr_checker #(.N_EDGES(N_EDGES), .AW(AW)) u_chk (.*);

// File: tb/tb_fifo_rr_ctrl.sv
module tb_fifo_rr_ctrl;
  localparam int DEPTH = 4096;
  localparam int AW    = $clog2(DEPTH);
  localparam int NE    = 4;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, rtx_n = 1'b1;
  logic prog_par = 1'b1, bm_en = 1'b1, size_byte = 1'b1, big_endian = 1'b1;
  logic [1:0] off_sel = 2'd1;
  logic wr_inc = 1'b0, rd_inc = 1'b0;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic rd_reload, obuf_clr, rst_done_a, rst_done_b, rst_bad_a, rst_bad_b;
  logic cfg_serial, cfg_big_end;
  logic [6:0] cfg_offset;
  logic [1:0] cfg_width;

  int n_chk = 0, n_err = 0;

  fifo_rr_ctrl #(.DEPTH(DEPTH), .N_EDGES(NE)) dut (.*);

  always #2 clk_a = ~clk_a;                        // 250 MHz
  initial begin #3; forever begin clk_b = 1'b1; #3; clk_b = 1'b0; #3; end end

  // ---- bench model, written from the requirements ----
  int ma_cnt = 0, mb_cnt = 0, m_wr = 0, m_rd = 0;
  bit ma_low = 0, mb_low = 0, ma_done = 0, mb_done = 0;
  bit mb_prev = 1, mb_hit = 0, m_rld = 0;

  always @(posedge clk_a) begin
    if (!mrst_n) begin
      ma_cnt <= ma_low ? ((ma_cnt < NE) ? ma_cnt + 1 : ma_cnt) : 1;
      ma_low <= 1; ma_done <= 0;
    end else begin
      ma_low <= 0;
      if (ma_low) ma_done <= (ma_cnt >= NE);
    end
    if (!mrst_n || !prst_n) m_wr <= 0;
    else if (wr_inc && ma_done) m_wr <= (m_wr + 1) % DEPTH;
  end

  always @(posedge clk_b) begin
    if (!mrst_n) begin
      mb_cnt <= mb_low ? ((mb_cnt < NE) ? mb_cnt + 1 : mb_cnt) : 1;
      mb_low <= 1; mb_done <= 0;
    end else begin
      mb_low <= 0;
      if (mb_low) mb_done <= (mb_cnt >= NE);
    end
    if (!mrst_n || !prst_n) begin
      m_rd <= 0; mb_prev <= 1; mb_hit <= 0; m_rld <= 0;
    end else begin
      mb_prev <= rtx_n;
      mb_hit  <= !rtx_n && mb_prev && mb_done;
      m_rld   <= mb_hit;
      if (mb_hit) m_rd <= 0;
      else if (rd_inc && mb_done) m_rd <= (m_rd + 1) % DEPTH;
    end
  end

  function automatic int exp_offset(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 64;
  endfunction
  function automatic int exp_width(input logic bm, input logic sz);
    return !bm ? 0 : (sz ? 2 : 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_a);
  endtask

  task automatic cmp_ptrs(input string tag);
    chk(wr_ptr == AW'(m_wr), {tag, " R8 wr_ptr"}, int'(wr_ptr), m_wr);
    chk(rd_ptr == AW'(m_rd), {tag, " R9/R10 rd_ptr"}, int'(rd_ptr), m_rd);
    chk(rd_reload == m_rld, {tag, " R10 rd_reload"}, int'(rd_reload), int'(m_rld));
  endtask

  initial begin
    #(200000 * 4);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(8);
    chk(wr_ptr == '0, "R1 wr_ptr in reset", int'(wr_ptr), 0);
    chk(rd_ptr == '0, "R1 rd_ptr in reset", int'(rd_ptr), 0);
    chk(obuf_clr == 1'b1, "R1 obuf_clr in reset", int'(obuf_clr), 1);
    chk(rst_done_a == 1'b0, "R6 done_a low in reset", int'(rst_done_a), 0);
    mrst_n = 1'b1;
    tick(3);
    chk(rst_done_a == 1'b1, "R6 done_a", int'(rst_done_a), 1);
    chk(rst_done_b == 1'b1, "R6 done_b", int'(rst_done_b), 1);
    chk(rst_bad_a == 1'b0 && rst_bad_b == 1'b0, "R7 no bad", int'(rst_bad_a), 0);
    chk(cfg_serial == 1'b0, "R4 serial", int'(cfg_serial), 0);
    chk(int'(cfg_offset) == exp_offset(2'd1), "R4 offset", int'(cfg_offset), 16);
    chk(int'(cfg_width) == exp_width(1'b1, 1'b1), "R5 width 9-bit", int'(cfg_width), 2);
    chk(cfg_big_end == 1'b1, "R3 endian", int'(cfg_big_end), 1);
    // inputs change outside master reset: ignored
    prog_par = 1'b0; off_sel = 2'd0; size_byte = 1'b0; big_endian = 1'b0;
    tick(4);
    chk(int'(cfg_offset) == 16 && cfg_width == 2'd2 && !cfg_serial && cfg_big_end,
        "R3 cfg held", int'(cfg_offset), 16);

    // random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      wr_inc = 1'($urandom_range(0, 1));
      rd_inc = 1'($urandom_range(0, 3) != 0);
      rtx_n  = !(($urandom_range(0, 40) == 0) && rtx_n);
      tick(1);
      cmp_ptrs("rand");
    end
    rtx_n = 1'b1; tick(3);

    // directed retransmit with rd_inc high, wr_inc low
    rd_inc = 1'b1; wr_inc = 1'b0;
    tick(5);
    begin
      logic [AW-1:0] w0;
      bit seen;
      w0 = wr_ptr; seen = 0;
      rtx_n = 1'b0; tick(2); rtx_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (rd_reload) begin
          seen = 1;
          chk(rd_ptr == '0, "R10 rd_ptr at reload", int'(rd_ptr), 0);
        end
        tick(1);
      end
      chk(seen, "R10 reload pulse", int'(seen), 1);
      chk(wr_ptr == w0, "R10 wr_ptr untouched", int'(wr_ptr), int'(w0));
    end
    cmp_ptrs("dir");

    // wrap of the write pointer
    rd_inc = 1'b0; wr_inc = 1'b1;
    begin
      int w0;
      w0 = int'(wr_ptr);
      tick(DEPTH);
      chk(int'(wr_ptr) == w0, "R8 wrap full turn", int'(wr_ptr), w0);
    end
    cmp_ptrs("wrap");
    wr_inc = 1'b0;

    // partial reset with changed cfg inputs
    prog_par = 1'b1; off_sel = 2'd2; bm_en = 1'b0;
    prst_n = 1'b0; tick(3);
    chk(wr_ptr == '0 && rd_ptr == '0, "R2 ptrs cleared", int'(wr_ptr), 0);
    chk(obuf_clr == 1'b1, "R2 obuf_clr", int'(obuf_clr), 1);
    prst_n = 1'b1; tick(3);
    chk(rst_done_a && rst_done_b, "R2 done kept", int'(rst_done_a), 1);
    chk(int'(cfg_offset) == 16 && cfg_width == 2'd2 && !cfg_serial, "R2 cfg kept",
        int'(cfg_offset), 16);
    chk(obuf_clr == 1'b0, "R2 obuf_clr released", int'(obuf_clr), 0);

    // short master reset: 2 Port A edges
    mrst_n = 1'b0; tick(2); mrst_n = 1'b1; tick(3);
    chk(rst_bad_a == 1'b1 && rst_done_a == 1'b0, "R7 bad_a", int'(rst_bad_a), 1);
    chk(rst_bad_b == 1'b1 && rst_done_b == 1'b0, "R7 bad_b", int'(rst_bad_b), 1);
    wr_inc = 1'b1; rd_inc = 1'b1; tick(5);
    chk(wr_ptr == '0, "R8 wr_inc ignored when not done", int'(wr_ptr), 0);
    chk(rd_ptr == '0, "R9 rd_inc ignored when not done", int'(rd_ptr), 0);
    wr_inc = 1'b0; rd_inc = 1'b0;
    begin
      bit any;
      any = 0;
      rtx_n = 1'b0; tick(2); rtx_n = 1'b1;
      for (int i = 0; i < 5; i++) begin any |= rd_reload; tick(1); end
      chk(!any, "R11 rtx ignored", int'(any), 0);
    end

    // full master reset with new configuration
    prog_par = 1'b0; off_sel = 2'd3; bm_en = 1'b0; size_byte = 1'b1; big_endian = 1'b0;
    mrst_n = 1'b0; tick(6);
    chk(rst_bad_a == 1'b0 && rst_bad_b == 1'b0, "R7 bad cleared", int'(rst_bad_a), 0);
    mrst_n = 1'b1; tick(3);
    chk(rst_done_a && rst_done_b, "R6 done after re-reset", int'(rst_done_b), 1);
    chk(int'(cfg_offset) == exp_offset(2'd3), "R4 offset sel3", int'(cfg_offset), 64);
    chk(cfg_serial == 1'b1, "R4 serial set", int'(cfg_serial), 1);
    chk(int'(cfg_width) == exp_width(1'b0, 1'b1), "R5 width 36-bit", int'(cfg_width), 0);
    chk(cfg_big_end == 1'b0, "R3 endian relatched", int'(cfg_big_end), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule